// File: doc/BRIEF.md
# Dot-Matrix Row Scanner with Cursor Overlay

This block refreshes a row of four 5x7 dot-matrix digits by time multiplexing. A prescaler splits time into row slots. In each slot one of the seven row lines is driven and, for every digit at once, the five column bits of that row are produced. Each digit's stored 7-bit character code goes out on a combinational font lookup port together with the current row number, and the returned five bits become that digit's columns.

A live cursor-enable input overrides the character for every digit whose cursor flag is set. It shows a full block (all 35 dots) at half brightness, which the block produces by lighting the columns only on alternate clocks of the slot. A flashing cursor is made simply by toggling the input. The per-digit enables come from a separate blanking decision and force a digit's columns dark. The first clock of every slot is always dark, so column data never overlaps a row change.

Top module: `dotmatrix_scan`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, `row_sel` is 7'b0000001 (row 0) and `col_out` is all zero.
- R2: Exactly one bit of `row_sel` is high at all times, and it is the bit indexed by `font_row`.
- R3: Each row slot lasts SLOT_CYCLES clocks (default 8). Rows advance 0,1,...,6 and then wrap to 0, so row r is selected during clocks n with (n / SLOT_CYCLES) mod 7 == r, counting n from 0 at the first clock after reset.
- R4: In the first clock of every slot ((n mod SLOT_CYCLES) == 0), all of `col_out` is zero.
- R5: `font_code[d*7 +: 7]` equals `char_codes[d*7 +: 7]` for every digit d, and `font_row` equals the current row number.
- R6: Outside the first slot clock, an enabled digit d with no cursor shown drives `col_out[d*5 +: 5]` = `font_bits[d*5 +: 5]` bit for bit. Digit 0 therefore occupies bits 4:0, the rightmost position.
- R7: When `cursor_en` is 1 and `cursor_flags[d]` is 1, an enabled digit d drives all five columns high in the odd clocks of the slot and all low in the even clocks, whatever its character.
- R8: When `cursor_en` is 0, `cursor_flags` has no effect and every enabled digit shows its character as in R6.
- R9: When `digit_en[d]` is 0, `col_out[d*5 +: 5]` is zero.
- R10: A change of `cursor_en` affects `col_out` in the same clock, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_codes | input | 28 | Four 7-bit character codes, digit 0 in bits 6:0 |
| cursor_flags | input | 4 | Per-digit cursor flag |
| cursor_en | input | 1 | Live cursor enable: 1 shows the cursor where flagged |
| digit_en | input | 4 | Per-digit column enable from the blanking logic |
| font_bits | input | 20 | Five column bits returned by the font lookup for each digit |
| font_code | output | 28 | Character code presented to the font lookup for each digit |
| font_row | output | 3 | Row number presented to the font lookup |
| row_sel | output | 7 | One-hot row select |
| col_out | output | 20 | Column drive, digit 0 in bits 4:0 |

## Verification
Only the slot counter and the row index are registered. The row and the slot phase therefore follow from the number of rising edges since reset was released, and every column result is a same-clock function of those and the current inputs. The bench keeps its own edge count and drives inputs at the falling edge. It compares one time unit later, so each check sees the state left by the previous rising edge. The cursor-enable check changes the input and compares in that same half cycle, which confirms that no register lies on that path.

// File: rtl/dms_pkg.sv
`timescale 1ns/1ps
package dms_pkg;

   typedef enum logic [1:0] {
      LANE_DARK   = 2'd0,
      LANE_GLYPH  = 2'd1,
      LANE_BLOCK  = 2'd2
   } lane_mode_e;

   function automatic lane_mode_e pick_mode(input logic enable,
                                            input logic slot_first,
                                            input logic show_cursor);
      if (!enable || slot_first) return LANE_DARK;
      if (show_cursor)           return LANE_BLOCK;
      return LANE_GLYPH;
   endfunction

endpackage

// File: rtl/dms_prescaler.sv
`timescale 1ns/1ps
module dms_prescaler #(
   parameter int SLOT_CYCLES = 8,
   parameter int ROWS        = 7,
   localparam int CNT_W      = $clog2(SLOT_CYCLES),
   localparam int ROW_W      = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [ROW_W-1:0] row_idx,
   output logic             slot_first,
   output logic             phase_odd
);

   logic [CNT_W-1:0] slot_cnt;
   logic             slot_last;

   assign slot_last  = (slot_cnt == CNT_W'(SLOT_CYCLES - 1));
   assign slot_first = (slot_cnt == '0);
   assign phase_odd  = slot_cnt[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_cnt <= '0;
      end else if (slot_last) begin
         slot_cnt <= '0;
      end else begin
         slot_cnt <= slot_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_idx <= '0;
      end else if (slot_last) begin
         if (row_idx == ROW_W'(ROWS - 1)) row_idx <= '0;
         else                              row_idx <= row_idx + 1'b1;
      end
   end

endmodule

// File: rtl/dms_row_decoder.sv
`timescale 1ns/1ps
module dms_row_decoder #(
   parameter int ROWS   = 7,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic [ROW_W-1:0] row_idx,
   output logic [ROWS-1:0]  row_sel
);

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      assign row_sel[i] = (row_idx == ROW_W'(i));
   end

endmodule

// File: rtl/dms_digit_lane.sv
`timescale 1ns/1ps
module dms_digit_lane
   import dms_pkg::*;
#(
   parameter int COLS   = 5,
   parameter int CODE_W = 7
) (
   input  logic [CODE_W-1:0] char_code,
   input  logic [COLS-1:0]   glyph_bits,
   input  logic              cursor_flag,
   input  logic              cursor_en,
   input  logic              enable,
   input  logic              slot_first,
   input  logic              phase_odd,
   output logic [CODE_W-1:0] lookup_code,
   output logic [COLS-1:0]   cols
);

   lane_mode_e mode;

   assign lookup_code = char_code;
   assign mode        = pick_mode(enable, slot_first, cursor_en & cursor_flag);

   always_comb begin
      unique case (mode)
         LANE_GLYPH: cols = glyph_bits;
         LANE_BLOCK: cols = phase_odd ? {COLS{1'b1}} : '0;
         default:    cols = '0;
      endcase
   end

endmodule

// File: rtl/dotmatrix_scan.sv
`timescale 1ns/1ps
module dotmatrix_scan #(
   parameter int NUM_DIGITS  = 4,
   parameter int COLS        = 5,
   parameter int ROWS        = 7,
   parameter int CODE_W      = 7,
   parameter int SLOT_CYCLES = 8,
   localparam int ROW_W      = $clog2(ROWS),
   localparam int COL_TOTAL  = NUM_DIGITS * COLS,
   localparam int CODE_TOTAL = NUM_DIGITS * CODE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CODE_TOTAL-1:0] char_codes,
   input  logic [NUM_DIGITS-1:0] cursor_flags,
   input  logic                  cursor_en,
   input  logic [NUM_DIGITS-1:0] digit_en,
   input  logic [COL_TOTAL-1:0]  font_bits,
   output logic [CODE_TOTAL-1:0] font_code,
   output logic [ROW_W-1:0]      font_row,
   output logic [ROWS-1:0]       row_sel,
   output logic [COL_TOTAL-1:0]  col_out
);

   if (SLOT_CYCLES < 4 || (SLOT_CYCLES % 2) != 0) begin : g_bad_slot
      $error("SLOT_CYCLES must be even and at least 4");
   end
   if (ROWS < 2 || COLS < 1 || NUM_DIGITS < 1) begin : g_bad_geom
      $error("matrix geometry out of range");
   end
   if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
      $error("CODE_W must be 1..8");
   end

   logic [ROW_W-1:0] row_idx;
   logic             slot_first;
   logic             phase_odd;

   dms_prescaler #(
      .SLOT_CYCLES (SLOT_CYCLES),
      .ROWS        (ROWS)
   ) u_prescaler (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_idx    (row_idx),
      .slot_first (slot_first),
      .phase_odd  (phase_odd)
   );

   dms_row_decoder #(
      .ROWS (ROWS)
   ) u_rowdec (
      .row_idx (row_idx),
      .row_sel (row_sel)
   );

   assign font_row = row_idx;

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_lane
      dms_digit_lane #(
         .COLS   (COLS),
         .CODE_W (CODE_W)
      ) u_lane (
         .char_code   (char_codes[d*CODE_W +: CODE_W]),
         .glyph_bits  (font_bits[d*COLS +: COLS]),
         .cursor_flag (cursor_flags[d]),
         .cursor_en   (cursor_en),
         .enable      (digit_en[d]),
         .slot_first  (slot_first),
         .phase_odd   (phase_odd),
         .lookup_code (font_code[d*CODE_W +: CODE_W]),
         .cols        (col_out[d*COLS +: COLS])
      );
   end

endmodule

// File: rtl/dotmatrix_scan_chk.sv
`timescale 1ns/1ps
module dotmatrix_scan_chk #(
   parameter int NUM_DIGITS = 4,
   parameter int COLS       = 5,
   parameter int ROWS       = 7,
   localparam int ROW_W     = $clog2(ROWS),
   localparam int COL_TOTAL = NUM_DIGITS * COLS
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_DIGITS-1:0] cursor_flags,
   input logic                  cursor_en,
   input logic [NUM_DIGITS-1:0] digit_en,
   input logic [COL_TOTAL-1:0]  font_bits,
   input logic [ROW_W-1:0]      font_row,
   input logic [ROWS-1:0]       row_sel,
   input logic [COL_TOTAL-1:0]  col_out
);

   logic [ROWS-1:0] prev_row;
   always_ff @(posedge clk) prev_row <= row_sel;

   // R2
   row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(row_sel) == 1) && row_sel[font_row]);

   // R3
   row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_sel != prev_row) |-> (row_sel == {prev_row[ROWS-2:0], prev_row[ROWS-1]}));

   // R4
   row_change_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_sel != prev_row) |-> (col_out == '0));

   for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dchk
      // R9
      lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !digit_en[d] |-> (col_out[d*COLS +: COLS] == '0));

      // R7
      cursor_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cursor_en && cursor_flags[d]) |->
            (col_out[d*COLS +: COLS] == '0 || col_out[d*COLS +: COLS] == {COLS{1'b1}}));

      // R8
      glyph_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!cursor_en && col_out[d*COLS +: COLS] != '0) |->
            (col_out[d*COLS +: COLS] == font_bits[d*COLS +: COLS]));
   end

endmodule

bind dotmatrix_scan dotmatrix_scan_chk #(
   .NUM_DIGITS (NUM_DIGITS),
   .COLS       (COLS),
   .ROWS       (ROWS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cursor_flags (cursor_flags),
   .cursor_en    (cursor_en),
   .digit_en     (digit_en),
   .font_bits    (font_bits),
   .font_row     (font_row),
   .row_sel      (row_sel),
   .col_out      (col_out)
);

// File: tb/test_dotmatrix_scan.sv
`timescale 1ns/1ps
module test_dotmatrix_scan;

   localparam int ND  = 4;
   localparam int NC  = 5;
   localparam int NR  = 7;
   localparam int CW  = 7;
   localparam int DIV = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [ND*CW-1:0] char_codes = '0;
   logic [ND-1:0]   cursor_flags = '0;
   logic            cursor_en = 1'b0;
   logic [ND-1:0]   digit_en = '1;
   logic [ND*NC-1:0] font_bits;
   logic [ND*CW-1:0] font_code;
   logic [2:0]      font_row;
   logic [NR-1:0]   row_sel;
   logic [ND*NC-1:0] col_out;

   int checks = 0;
   int errors = 0;
   int n = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [4:0] fmodel(input logic [6:0] code, input logic [2:0] row);
      int v;
      v = int'(code) * 3 + int'(row) * 7 + 1;
      return v[4:0];
   endfunction

   always_comb begin
      for (int d = 0; d < ND; d++)
         font_bits[d*NC +: NC] = fmodel(font_code[d*CW +: CW], font_row);
   end

   dotmatrix_scan #(
      .NUM_DIGITS (ND), .COLS (NC), .ROWS (NR), .CODE_W (CW), .SLOT_CYCLES (DIV)
   ) i_dotmatrix_scan (
      .clk (clk), .rst_n (rst_n), .char_codes (char_codes),
      .cursor_flags (cursor_flags), .cursor_en (cursor_en), .digit_en (digit_en),
      .font_bits (font_bits), .font_code (font_code), .font_row (font_row),
      .row_sel (row_sel), .col_out (col_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, n);
      end
   endtask

   task automatic check_cycle();
      int k, r;
      k = n % DIV;
      r = (n / DIV) % NR;
      check("R3 row select", 32'(row_sel), 32'(1 << r));
      check("R2 single row", 32'($countones(row_sel)), 32'd1);
      check("R5 font row", 32'(font_row), 32'(r));
      for (int d = 0; d < ND; d++) begin
         logic [6:0] code;
         logic [4:0] exp;
         string tag;
         code = char_codes[d*CW +: CW];
         check("R5 font code", 32'(font_code[d*CW +: CW]), 32'(code));
         if (!digit_en[d]) begin
            exp = '0; tag = "R9 disabled digit";
         end else if (k == 0) begin
            exp = '0; tag = "R4 slot start dark";
         end else if (cursor_en && cursor_flags[d]) begin
            exp = (k % 2 == 1) ? 5'h1F : 5'h00; tag = "R7 cursor block";
         end else if (!cursor_en && cursor_flags[d]) begin
            exp = fmodel(code, 3'(r)); tag = "R8 flag ignored";
         end else begin
            exp = fmodel(code, 3'(r)); tag = "R6 glyph columns";
         end
         check(tag, 32'(col_out[d*NC +: NC]), 32'(exp));
      end
   endtask

   task automatic step();
      @(posedge clk);
      n++;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check("R1 reset rows", 32'(row_sel), 32'd1);
      check("R1 reset cols", 32'(col_out), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      #1;
      check("R1 first clock rows", 32'(row_sel), 32'd1);
      check("R1 first clock cols", 32'(col_out), 32'd0);
      @(negedge clk);
      n = 1;
      for (int p = 0; p < 32; p++) begin
         cursor_en    = p[0];
         cursor_flags = 4'(p >> 1);
         digit_en     = (p >= 24) ? 4'(4'hF ^ (1 << (p % 4))) : 4'hF;
         for (int d = 0; d < ND; d++)
            char_codes[d*CW +: CW] = 7'((p * 13 + d * 29 + 5) % 128);
         for (int c = 0; c < NR * DIV + 3; c++) begin
            #1;
            check_cycle();
            step();
         end
      end
      // R10: live cursor-enable switch within one clock
      cursor_en = 1'b0; cursor_flags = 4'hF; digit_en = 4'hF;
      while (n % DIV != 1) step();
      #1;
      check("R10 before switch", 32'(col_out[4:0]),
            32'(fmodel(char_codes[6:0], 3'((n / DIV) % NR))));
      cursor_en = 1'b1;
      #1;
      check("R10 after switch", 32'(col_out[4:0]), 32'h1F);
      cursor_en = 1'b0;
      #1;
      check("R10 switch back", 32'(col_out[4:0]),
            32'(fmodel(char_codes[6:0], 3'((n / DIV) % NR))));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule